// File: doc/BRIEF.md
# Hybrid Cycle Delay Guard

This block raises a guard a fixed number of clock cycles after a trigger pulse, and it keeps all of its timing in local state. No free-running timestamp, no shared counter and no wide compare bus is involved. The delay `DELAY_K` is fixed at elaboration. The parameter `SHIFT_MAX` picks the structure:

- **Short delays.** A valid bit walks down a chain of `DELAY_K` flops.
- **Long delays.** A single local counter is armed and compared against `DELAY_K`. This costs far fewer flops on long intervals.

By default the guard is a one-cycle pulse, which suits consumers that sample at a known time. Setting `STICKY` gives a latency-insensitive variant: the guard rises on schedule and then holds until the consumer signals `fireAck`, so a late consumer never loses the event. The counter form can time only one interval at a time. A trigger that arrives while it is busy is dropped and recorded in a sticky `overrun` flag. A `DELAY_K` of zero stops elaboration.

Top module: `delay_guard_top`

## Requirements
- R1: A trigger sampled high at rising edge E produces a guard pulse in the cycle that follows rising edge E+`DELAY_K-1`. The guard is therefore high in cycle n+`DELAY_K` for a trigger driven in cycle n.
- R2: When `DELAY_K` <= `SHIFT_MAX` (default 16), triggers may overlap. Every accepted trigger yields its own guard pulse, including triggers on consecutive cycles.
- R3: When `DELAY_K` > `SHIFT_MAX`, only one interval is timed. A trigger is ignored from the edge that arms the counter through the cycle in which the guard is high. An ignored trigger produces no later pulse.
- R4: `overrun` goes high on the edge after a trigger that was ignored under R3 and stays high until reset. In shift mode `overrun` is always low.
- R5: With `STICKY`=0 the guard is high for exactly one cycle per accepted trigger, and `fireAck` has no effect on any output.
- R6: With `STICKY`=1 the guard rises as in R1 and stays high through every cycle until one in which `fireAck` is high. It is low on the cycle after that, unless a new pulse is due.
- R7: With `STICKY`=1, `fireAck` while the guard is low has no effect. `fireAck` in the very cycle the guard rises consumes it, so the guard is high for only that one cycle.
- R8: While `rstN` is low, `guard` and `overrun` are low. Reset discards every pending interval, the counter and the held guard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Starts a delay interval when sampled high |
| fireAck | input | 1 | Consumer took the guard (sticky mode only) |
| guard | output | 1 | Guard output, pulse or held depending on `STICKY` |
| overrun | output | 1 | Sticky flag: a trigger was dropped by the busy counter |

## Verification
Three configurations run side by side on the same inputs, each against a behavioural model built from due-time queues:

- a 5-cycle shift chain,
- a 20-cycle counter,
- a 3-cycle sticky chain.

Isolated triggers pin the exact delay. Triggers two cycles apart separate independent tracking in the chain from dropping plus `overrun` in the counter. Held-low and stuck-high `fireAck` patterns separate a held guard from a pulse, and they expose a clear that happens at the wrong cycle. A long random phase and a reset in the middle of pending intervals cover overlaps, releases in the same cycle as a rise, and discarding of pending state.

// File: rtl/delay_guard_pkg.sv
package delay_guard_pkg;

  typedef struct packed {
    logic launch;
  } guardStrobes_t;

endpackage

// File: rtl/delay_guard_dp.sv
module delay_guard_dp
  import delay_guard_pkg::*;
#(
  parameter int DELAY_K   = 8,
  parameter bit USE_SHIFT = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  guardStrobes_t strobes,
  output logic          pulse,
  output logic          busy
);

  generate
    if (USE_SHIFT) begin : gChain
      logic [DELAY_K-1:0] chainQ;

      if (DELAY_K == 1) begin : gOne
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ <= '0;
          else       chainQ <= strobes.launch;
        end
      end else begin : gMany
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ <= '0;
          else       chainQ <= {chainQ[DELAY_K-2:0], strobes.launch};
        end
      end

      assign pulse = chainQ[DELAY_K-1];
      assign busy  = 1'b0;

    end else begin : gCounter
      localparam int CNT_W = $clog2(DELAY_K + 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_K);

      logic [CNT_W-1:0] cntQ;
      logic             runQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cntQ <= '0;
          runQ <= 1'b0;
        end else if (strobes.launch) begin
          cntQ <= CNT_W'(1);
          runQ <= 1'b1;
        end else if (runQ) begin
          if (cntQ == LAST) begin
            cntQ <= '0;
            runQ <= 1'b0;
          end else begin
            cntQ <= cntQ + CNT_W'(1);
          end
        end
      end

      assign pulse = runQ && (cntQ == LAST);
      assign busy  = runQ;

      // R3: while running, the count stays inside 1..DELAY_K
      a_r3_count_range: assert property (@(posedge clk) disable iff (!rstN)
        runQ |-> (cntQ != '0 && cntQ <= LAST));

      // R5: the counter form can never emit two pulses back to back
      a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
        pulse |=> !pulse);
    end
  endgenerate

endmodule

// File: rtl/delay_guard_ctrl.sv
module delay_guard_ctrl
  import delay_guard_pkg::*;
#(
  parameter bit STICKY = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigger,
  input  logic          fireAck,
  input  logic          pulse,
  input  logic          busy,
  output guardStrobes_t strobes,
  output logic          guard,
  output logic          overrun
);

  logic heldQ;
  logic overrunQ;

  always_comb begin
    strobes        = '0;
    strobes.launch = trigger && !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldQ    <= 1'b0;
      overrunQ <= 1'b0;
    end else begin
      heldQ    <= STICKY && (heldQ || pulse) && !fireAck;
      overrunQ <= overrunQ || (trigger && busy);
    end
  end

  assign guard   = STICKY ? (pulse || heldQ) : pulse;
  assign overrun = overrunQ;

  // R4: overrun only ever rises after a trigger was presented
  a_r4_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(trigger));

  generate
    if (STICKY) begin : gStickyChecks
      // R6: a raised guard is held until it is consumed
      a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
        (guard && !fireAck) |=> guard);

      // R7: the guard only falls after an acknowledge
      a_r7_fall_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
        $fell(guard) |-> $past(fireAck));
    end
  endgenerate

endmodule

// File: rtl/delay_guard_top.sv
module delay_guard_top
  import delay_guard_pkg::*;
#(
  parameter int DELAY_K   = 8,
  parameter int SHIFT_MAX = 16,
  parameter bit STICKY    = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigger,
  input  logic fireAck,
  output logic guard,
  output logic overrun
);

  localparam bit USE_SHIFT = (DELAY_K <= SHIFT_MAX);

  generate
    if (DELAY_K < 1) begin : gBadDelay
      $error("delay_guard_top: DELAY_K must be at least 1");
    end
  endgenerate

  guardStrobes_t strobes;
  logic          pulse;
  logic          busy;

  delay_guard_ctrl #(
    .STICKY (STICKY)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .trigger (trigger),
    .fireAck (fireAck),
    .pulse   (pulse),
    .busy    (busy),
    .strobes (strobes),
    .guard   (guard),
    .overrun (overrun)
  );

  delay_guard_dp #(
    .DELAY_K   (DELAY_K),
    .USE_SHIFT (USE_SHIFT)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pulse   (pulse),
    .busy    (busy)
  );

  // R1: the guard is never high while in reset recovery with nothing timed
  a_r1_guard_after_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guard) |-> !$past(!rstN));

endmodule

// File: tb/tb_delay_guard_top.sv
`timescale 1ns/1ps
module tb_delay_guard_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trig = 1'b0;
  logic ack = 1'b0;
  logic g0, o0, g1, o1, g2, o2;

  always #4 clk = ~clk;

  delay_guard_top #(.DELAY_K(5), .SHIFT_MAX(16), .STICKY(1'b0)) dut (
    .clk(clk), .rstN(rstN), .trigger(trig), .fireAck(ack), .guard(g0), .overrun(o0));
  delay_guard_top #(.DELAY_K(20), .SHIFT_MAX(16), .STICKY(1'b0)) dutCnt (
    .clk(clk), .rstN(rstN), .trigger(trig), .fireAck(ack), .guard(g1), .overrun(o1));
  delay_guard_top #(.DELAY_K(3), .SHIFT_MAX(16), .STICKY(1'b1)) dutSticky (
    .clk(clk), .rstN(rstN), .trigger(trig), .fireAck(ack), .guard(g2), .overrun(o2));

  int checks = 0;
  int fails = 0;
  int n = 0;
  bit done = 1'b0;

  int q0[$];
  int q1[$];
  int q2[$];
  bit heldM [3];
  bit ovrM [3];

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, n);
    end
  endtask

  // One configuration: compare current outputs, then advance with the inputs being driven
  task automatic model(input int c, input int k, input bit cntMode, input bit sticky,
                       input logic actG, input logic actO, input string gTag,
                       input bit t, input bit a);
    int q[$];
    bit pulse;
    case (c)
      0: q = q0;
      1: q = q1;
      default: q = q2;
    endcase
    pulse = (q.size() > 0) && (q[0] == n);
    check(gTag, actG, pulse | heldM[c]);
    check("R4 overrun", actO, ovrM[c]);
    if (t) begin
      if (cntMode && q.size() > 0) ovrM[c] = 1'b1;
      else q.push_back(n + k);
    end
    if (pulse) void'(q.pop_front());
    heldM[c] = sticky && (heldM[c] || pulse) && !a;
    case (c)
      0: q0 = q;
      1: q1 = q;
      default: q2 = q;
    endcase
  endtask

  task automatic tick(input bit t, input bit a);
    @(negedge clk);
    model(0, 5,  1'b0, 1'b0, g0, o0, "R1/R2/R5 shift guard", t, a);
    model(1, 20, 1'b1, 1'b0, g1, o1, "R1/R3 counter guard", t, a);
    model(2, 3,  1'b0, 1'b1, g2, o2, "R6/R7 sticky guard", t, a);
    trig = t;
    ack = a;
    n++;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    trig = 1'b0;
    ack = 1'b0;
    q0.delete(); q1.delete(); q2.delete();
    for (int c = 0; c < 3; c++) begin heldM[c] = 1'b0; ovrM[c] = 1'b0; end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 guard in reset", g0 | g1 | g2, 1'b0);
      check("R8 overrun in reset", o0 | o1 | o2, 1'b0);
    end
    rstN = 1'b1;
    n = 1;
  endtask

  initial begin
    doReset();
    // isolated trigger: exact delay in every structure (R1)
    tick(1, 0);
    for (int i = 0; i < 30; i++) tick(0, 0);
    // triggers two apart: chain tracks both (R2), counter drops second (R3, R4)
    tick(1, 0); tick(0, 0); tick(1, 0);
    for (int i = 0; i < 30; i++) tick(0, 0);
    // sticky hold with ack low, then released (R6); ack while low ignored (R7)
    tick(0, 1); tick(1, 1); tick(0, 1);
    for (int i = 0; i < 10; i++) tick(0, 0);
    tick(0, 1);
    for (int i = 0; i < 25; i++) tick(0, 0);
    // ack stuck high: pulses only (R5, R7)
    for (int i = 0; i < 40; i++) tick((i % 7) == 0, 1);
    for (int i = 0; i < 25; i++) tick(0, 0);
    // random traffic
    for (int i = 0; i < 2000; i++) tick(($urandom % 8) == 0, ($urandom % 4) == 0);
    // reset with intervals pending (R8)
    tick(1, 0); tick(1, 0);
    doReset();
    for (int i = 0; i < 30; i++) tick(0, 0);
    for (int i = 0; i < 1000; i++) tick(($urandom % 5) == 0, ($urandom % 3) == 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule